// File: doc/BRIEF.md
# Lockable Thermal Trip Register Block

This block holds the settings of an on-die thermal monitor behind a small 32-bit register bus. Boot firmware programs an 8-bit critical temperature in degrees Centigrade, a 32-bit calibration slope and a shutdown enable. It then seals the block by writing a one to a lock bit. Once sealed, the limit, the slope and the enable keep their values until the next global reset. Software has no way to clear the lock, and a write of zero does nothing.

The block samples the converted temperature from the sensor front end on every clock. It raises a registered shutdown request while the enable is set and the temperature is at or above the limit. The shutdown enable sits under the same lock as the limit, so a sealed block cannot be talked out of its protective response. The lock is a two-state machine. `SEAL_OPEN` is the reset state. The transition `open_to_shut` is taken on a bus write of 1 in bit 0 to the lock word, and it leads to `SEAL_SHUT`. `SEAL_SHUT` has no exit other than the active-low reset.

Top module: `thermlock_top`

## Requirements
- R1: After the active-low reset `rst_n`, the block reads back these values: limit 125, calibration `CALIB_RST` (default 0x0000_0100), lock 0, shutdown enable 0 and current temperature 0. `shutdown_o` is 0.
- R2: Offset 0x00 holds the critical limit in bits [7:0], which can be read and written. Bits [31:8] always read as zero.
- R3: Offset 0x04 holds the full 32-bit calibration slope, which can be read and written.
- R4: The lock is bit 0 of offset 0x08. Writing a 1 sets it, taking the FSM from `SEAL_OPEN` to `SEAL_SHUT`. Writing a 0 never clears it. Only `rst_n` returns it to 0. The other bits read as zero.
- R5: While the lock reads 1, writes to offsets 0x00 and 0x04 leave their contents unchanged.
- R6: The shutdown enable is bit 1 of offset 0x0C, and all other bits of that word read as zero. While the lock reads 1, writes to 0x0C leave the enable unchanged.
- R7: Offset 0x10 is read-only. Bits [7:0] give the temperature sampled at the previous clock edge, and bits [31:8] read as zero. Writes to it have no effect.
- R8: `shutdown_o` equals 1 in the cycle after an edge at which the enable was 1 and `temp_i` was greater than or equal to the limit. Otherwise it is 0 in that cycle. The comparison is unsigned and includes equality.
- R9: A read of any other offset returns zero, and so does a read of an address whose two low bits are not zero. Writes to such addresses change no register.
- R10: `bus_rdata` is a combinational function of `bus_addr` and the register contents, valid in the same cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low global reset, the only way to unlock |
| bus_addr | input | ADDR_W (8) | Byte address of the register word |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` |
| temp_i | input | TEMP_W (8) | Converted temperature from the sensor front end |
| shutdown_o | output | 1 | Registered critical-temperature shutdown request |

## Verification
The assertions assume that `rst_n` is asserted at start-up. They also assume that bus inputs and `temp_i` change only between clock edges. The stickiness and freeze properties assume that no reset arrives inside the window they observe, because a reset is the one legal way to reopen the block. The stimulus holds every input away from the rising edge, driving at the falling edge. It pulls reset only through a dedicated task that also resets the bench's model, and it keeps random temperatures near the programmed limit so that the equality boundary is hit often.

// File: rtl/thermlock_pkg.sv
package thermlock_pkg;

    typedef enum logic {
        SEAL_OPEN = 1'b0,
        SEAL_SHUT = 1'b1
    } seal_e;

    localparam int NUM_WORDS = 5;
    localparam int IDX_LIMIT = 0;
    localparam int IDX_CALIB = 1;
    localparam int IDX_LOCK  = 2;
    localparam int IDX_SHDN  = 3;
    localparam int IDX_TEMP  = 4;
    localparam int LOCK_BIT  = 0;
    localparam int SHDN_BIT  = 1;

endpackage

// File: rtl/thermlock_seal_fsm.sv
module thermlock_seal_fsm
    import thermlock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seal_req,
    output logic sealed
);

    seal_e state_q;
    seal_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEAL_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEAL_OPEN: if (seal_req) state_d = SEAL_SHUT;
            SEAL_SHUT: state_d = SEAL_SHUT;
        endcase
    end

    always_comb begin
        sealed = (state_q == SEAL_SHUT);
    end

endmodule

// File: rtl/thermlock_regs.sv
module thermlock_regs
    import thermlock_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          TEMP_W    = 8,
    parameter logic [TEMP_W-1:0] LIMIT_RST = 8'd125,
    parameter logic [DATA_W-1:0] CALIB_RST = 32'h0000_0100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [NUM_WORDS-1:0] sel,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 sealed,
    input  logic [TEMP_W-1:0]    temp_i,
    output logic                 seal_req,
    output logic [TEMP_W-1:0]    limit_q,
    output logic [DATA_W-1:0]    calib_q,
    output logic                 en_q,
    output logic [DATA_W-1:0]    rdata
);

    logic [TEMP_W-1:0] cur_q;
    logic              open_wr;
    logic [DATA_W-1:0] word [NUM_WORDS];

    assign open_wr  = we && !sealed;
    assign seal_req = we && sel[IDX_LOCK] && wdata[LOCK_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= LIMIT_RST;
            calib_q <= CALIB_RST;
            en_q    <= 1'b0;
            cur_q   <= '0;
        end else begin
            cur_q <= temp_i;
            if (open_wr && sel[IDX_LIMIT]) limit_q <= wdata[TEMP_W-1:0];
            if (open_wr && sel[IDX_CALIB]) calib_q <= wdata;
            if (open_wr && sel[IDX_SHDN])  en_q    <= wdata[SHDN_BIT];
        end
    end

    always_comb begin
        word[IDX_LIMIT]           = '0;
        word[IDX_LIMIT][TEMP_W-1:0] = limit_q;
        word[IDX_CALIB]           = calib_q;
        word[IDX_LOCK]            = '0;
        word[IDX_LOCK][LOCK_BIT]  = sealed;
        word[IDX_SHDN]            = '0;
        word[IDX_SHDN][SHDN_BIT]  = en_q;
        word[IDX_TEMP]            = '0;
        word[IDX_TEMP][TEMP_W-1:0] = cur_q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (sel[i]) rdata = rdata | word[i];
        end
    end

endmodule

// File: rtl/thermlock_trip.sv
module thermlock_trip #(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [TEMP_W-1:0] limit,
    input  logic [TEMP_W-1:0] temp_i,
    output logic              shutdown_o
);

    logic hot;

    assign hot = (temp_i >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shutdown_o <= 1'b0;
        end else begin
            shutdown_o <= en && hot;
        end
    end

endmodule

// File: rtl/thermlock_top.sv
module thermlock_top
    import thermlock_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter int          TEMP_W    = 8,
    parameter logic [TEMP_W-1:0] LIMIT_RST = 8'd125,
    parameter logic [DATA_W-1:0] CALIB_RST = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [TEMP_W-1:0] temp_i,
    output logic              shutdown_o
);

    localparam int IDX_W = ADDR_W - 2;

    logic [NUM_WORDS-1:0] sel_w;
    logic                 seal_req_w;
    logic                 locked_w;
    logic [TEMP_W-1:0]    limit_w;
    logic [DATA_W-1:0]    calib_w;
    logic                 en_w;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_dec
        assign sel_w[g] = (bus_addr[1:0] == 2'b00) &&
                          (bus_addr[ADDR_W-1:2] == IDX_W'(g));
    end

    thermlock_seal_fsm u_seal (
        .clk      (clk),
        .rst_n    (rst_n),
        .seal_req (seal_req_w),
        .sealed   (locked_w)
    );

    thermlock_regs #(
        .DATA_W    (DATA_W),
        .TEMP_W    (TEMP_W),
        .LIMIT_RST (LIMIT_RST),
        .CALIB_RST (CALIB_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (bus_we),
        .sel      (sel_w),
        .wdata    (bus_wdata),
        .sealed   (locked_w),
        .temp_i   (temp_i),
        .seal_req (seal_req_w),
        .limit_q  (limit_w),
        .calib_q  (calib_w),
        .en_q     (en_w),
        .rdata    (bus_rdata)
    );

    thermlock_trip #(
        .TEMP_W (TEMP_W)
    ) u_trip (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_w),
        .limit      (limit_w),
        .temp_i     (temp_i),
        .shutdown_o (shutdown_o)
    );

endmodule

// File: rtl/thermlock_sva.sv
module thermlock_sva #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int TEMP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              locked,
    input logic [TEMP_W-1:0] limit,
    input logic [DATA_W-1:0] calib,
    input logic              en,
    input logic [TEMP_W-1:0] temp_i,
    input logic              shutdown_o,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata
);

    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    assert_limit_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(limit));

    assert_calib_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(calib));

    assert_enable_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(en));

    assert_trip_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (temp_i >= limit)) |=> shutdown_o);

    assert_trip_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && (temp_i >= limit)) |=> !shutdown_o);

    assert_limit_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 8'h00) |-> (bus_rdata[DATA_W-1:TEMP_W] == '0));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr[1:0] != 2'b00) || (bus_addr > 8'h10)) |-> (bus_rdata == '0));

endmodule

bind thermlock_top thermlock_sva #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TEMP_W (TEMP_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .locked     (locked_w),
    .limit      (limit_w),
    .calib      (calib_w),
    .en         (en_w),
    .temp_i     (temp_i),
    .shutdown_o (shutdown_o),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata)
);

// File: tb/thermlock_top_tb.sv
module thermlock_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  temp_i = '0;
    logic        shutdown_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0]  m_lim;
    logic [31:0] m_cal;
    logic        m_lk;
    logic        m_en;
    logic [7:0]  m_cur;

    always #2 clk = ~clk;

    thermlock_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .temp_i     (temp_i),
        .shutdown_o (shutdown_o)
    );

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00:   return {24'h0, m_lim};
            8'h04:   return m_cal;
            8'h08:   return {31'h0, m_lk};
            8'h0C:   return {30'h0, m_en, 1'b0};
            8'h10:   return {24'h0, m_cur};
            default: return 32'h0;
        endcase
    endfunction

    function automatic void model_reset();
        m_lim = 8'd125;
        m_cal = 32'h0000_0100;
        m_lk  = 1'b0;
        m_en  = 1'b0;
        m_cur = 8'h0;
    endfunction

    function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h00: if (!m_lk) m_lim = d[7:0];
            8'h04: if (!m_lk) m_cal = d;
            8'h08: if (d[0]) m_lk = 1'b1;
            8'h0C: if (!m_lk) m_en = d[1];
            default: ;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        bus_we = 1'b0;
        temp_i = 8'h0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        model_write(a, d);
        m_cur = temp_i;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_read(a));
    endtask

    task automatic tick(input logic [7:0] t, input string tag);
        logic e;
        @(negedge clk);
        bus_we = 1'b0;
        temp_i = t;
        @(posedge clk);
        e = m_en && (t >= m_lim);
        m_cur = t;
        @(negedge clk);
        check(tag, {31'h0, shutdown_o}, {31'h0, e});
    endtask

    task automatic rd_all(input string tag);
        rd(8'h00, tag);
        rd(8'h04, tag);
        rd(8'h08, tag);
        rd(8'h0C, tag);
        rd(8'h10, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R1 reset values
        rd_all("R1 reset value");
        @(negedge clk);
        check("R1 shutdown after reset", {31'h0, shutdown_o}, 32'h0);

        // R2 limit field and zero upper bits
        wr(8'h00, 32'hFFFF_FF50);
        rd(8'h00, "R2 limit upper bits zero");
        // R3 full calibration word
        wr(8'h04, 32'hA5C3_0F1E);
        rd(8'h04, "R3 calibration readback");
        // R6 enable bit only
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, "R6 enable bit position");
        // R10 combinational read across address changes in one phase
        @(negedge clk);
        bus_we = 1'b0;
        bus_addr = 8'h04;
        #1 check("R10 same-cycle read a", bus_rdata, m_cal);
        bus_addr = 8'h00;
        #1 check("R10 same-cycle read b", bus_rdata, {24'h0, m_lim});

        // R8 boundaries
        tick(8'h50, "R8 temp equal to limit");
        tick(8'h4F, "R8 temp one below limit");
        tick(8'h51, "R8 temp above limit");
        wr(8'h00, 32'h0);
        tick(8'h00, "R8 zero limit zero temp");
        wr(8'h00, 32'hFF);
        tick(8'hFF, "R8 max limit max temp");
        tick(8'hFE, "R8 max limit below");
        wr(8'h0C, 32'h0);
        tick(8'hFF, "R8 disabled no trip");

        // R7 current temp read-only
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, "R7 temp write ignored");
        // R9 unmapped
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, "R9 unmapped read zero");
        wr(8'h01, 32'hFFFF_FFFF);
        rd(8'h01, "R9 misaligned read zero");
        rd_all("R9 no side effect");

        // R4 lock
        wr(8'h08, 32'hFFFF_FFFE);
        rd(8'h08, "R4 zero write does not set");
        wr(8'h00, 32'h64);
        wr(8'h0C, 32'h2);
        wr(8'h08, 32'h1);
        rd(8'h08, "R4 lock set");
        wr(8'h08, 32'h0);
        rd(8'h08, "R4 zero write does not clear");
        // R5 and R6 frozen while locked
        wr(8'h00, 32'h10);
        rd(8'h00, "R5 limit frozen");
        wr(8'h04, 32'h1234_5678);
        rd(8'h04, "R5 calibration frozen");
        wr(8'h0C, 32'h0);
        rd(8'h0C, "R6 enable frozen");
        tick(8'h64, "R8 locked trip at limit");
        tick(8'h63, "R8 locked below limit");

        // R4 only reset unlocks
        do_reset();
        rd_all("R4 R1 reset clears lock");

        // random phase
        void'($urandom(32'h1CE5_7A11));
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 500; i++) begin
                int op;
                logic [7:0] a;
                op = int'($urandom_range(0, 9));
                if (op < 4) begin
                    case ($urandom_range(0, 6))
                        0: a = 8'h00;
                        1: a = 8'h04;
                        2: a = ($urandom_range(0, 15) == 0) ? 8'h08 : 8'h0C;
                        3: a = 8'h0C;
                        4: a = 8'h10;
                        5: a = 8'h14;
                        default: a = 8'($urandom);
                    endcase
                    wr(a, $urandom);
                end else if (op < 7) begin
                    logic [7:0] t;
                    t = ($urandom_range(0, 1) == 1) ? 8'(m_lim + 8'($urandom_range(0, 2)) - 8'd1)
                                                    : 8'($urandom);
                    tick(t, "R8 random trip");
                end else begin
                    rd(8'($urandom_range(0, 24)), "R9 R5 random read");
                end
            end
            rd_all("R5 R6 random end state");
            do_reset();
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule